// File: doc/BRIEF.md
# SIMD Lane Carry-Out Generator

This block takes two 128-bit vector operands and a 4-bit lane-size code. It splits both operands into independent lanes of the selected width and adds each pair of lanes as unsigned numbers. It keeps only the carry that leaves the top bit of each lane. Each lane of the result holds that carry as the value 0 or 1, zero-extended to the full lane width. Carries never cross a lane boundary.

The supported lane widths are 8, 16, 32, 64 and a single 128-bit lane. All five widths are computed in parallel and the size code selects one of them. A size code outside the supported range gives no result. Instead it raises a specification-error flag, and the result bus reads zero.

An operation is accepted in any cycle where the input strobe is high. Its result and error flag are registered and appear on the next clock edge, together with a one-cycle output strobe. There is no back-pressure, so a new operation may be issued every cycle.

Top module: `lane_carry_gen`

## Requirements
- R1: Size codes 0, 1, 2, 3 and 4 select lane widths of 8, 16, 32, 64 and 128 bits.
- R2: An accepted size code of 5 or more sets `spec_err` to 1. A legal code clears it to 0.
- R3: While `spec_err` is 1, `res` is all zeros.
- R4: For a legal code, bit 0 of each result lane equals the unsigned carry out of the sum `a_lane + b_lane`, and every other bit of that lane is 0.
- R5: No carry passes from one lane into the next. A lane that overflows does not change the result of the lane above it.
- R6: With code 4, the carry comes from the full 128-bit sum, including a carry that ripples from bit 63 into bit 64. Only bit 0 of `res` can be nonzero.
- R7: Lane k occupies bits [k*W+W-1 : k*W] of each operand and of `res`, where W is the lane width. Lane 0 is the least significant.
- R8: `out_vld` is 1 in exactly the cycle after a cycle with `in_vld` high, and `res` and `spec_err` carry that operation's result in that cycle.
- R9: In a cycle where `in_vld` is low, the operand and code inputs are ignored. `res` and `spec_err` keep their previous values, and `out_vld` is 0.
- R10: A synchronous active-high reset clears `out_vld`, `res` and `spec_err` at the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| in_vld | input | 1 | Accept an operation this cycle |
| op_a | input | 128 | First vector operand |
| op_b | input | 128 | Second vector operand |
| size_code | input | 4 | Lane width select (0..4 legal) |
| out_vld | output | 1 | One-cycle result strobe |
| res | output | 128 | Per-lane zero-extended carry-out vector |
| spec_err | output | 1 | Illegal size code was accepted |

## Verification
The bench builds the block with its default 128-bit vector. In that configuration the 8-bit lanes hold sixteen pairs per vector, so all 65,536 byte operand pairs fit into 4,096 operations and the narrow-lane carry logic is covered exhaustively. The wider lanes use directed boundary patterns plus pseudo-random operands, all checked against a bit-serial ripple sum computed in the bench. Every illegal code from 5 to 15 is applied. Each operation is followed by an idle cycle with changed inputs, which exercises the hold behaviour.

// File: rtl/lcg_pkg.sv
package lcg_pkg;
    localparam int VEC_W       = 128;
    localparam int CODE_W      = 4;
    localparam int NUM_SIZES   = 5;
    localparam int MIN_LANE_W  = 8;

    typedef enum logic [1:0] {
        CARRY_MASKED_MSB = 2'd0,
        CARRY_COMPARE    = 2'd1,
        CARRY_SPLIT_HALF = 2'd2
    } carry_method_e;

    typedef struct packed {
        logic             vld;
        logic             err;
        logic [VEC_W-1:0] res;
    } out_state_t;

    function automatic carry_method_e method_for(input int lane_w);
        if (lane_w <= 16)      return CARRY_MASKED_MSB;
        else if (lane_w <= 64) return CARRY_COMPARE;
        else                   return CARRY_SPLIT_HALF;
    endfunction
endpackage

// File: rtl/lcg_msb_carry.sv
module lcg_msb_carry #(
    parameter int LANE_W = 8
) (
    input  logic [LANE_W-1:0] a,
    input  logic [LANE_W-1:0] b,
    output logic              carry
);
    localparam int LOW_W = LANE_W - 1;

    logic into_msb;

    // carry into the top bit: add the operands without their top bits
    assign into_msb = (({1'b0, a[LOW_W-1:0]} + {1'b0, b[LOW_W-1:0]})
                       >= {1'b1, {LOW_W{1'b0}}});

    assign carry = (a[LANE_W-1] & b[LANE_W-1])
                 | ((a[LANE_W-1] ^ b[LANE_W-1]) & into_msb);
endmodule

// File: rtl/lcg_cmp_carry.sv
module lcg_cmp_carry #(
    parameter int LANE_W = 32
) (
    input  logic [LANE_W-1:0] a,
    input  logic [LANE_W-1:0] b,
    output logic              carry
);
    logic [LANE_W-1:0] wrapped;

    assign wrapped = a + b;
    // a truncated sum below one addend means the addition wrapped
    assign carry   = (wrapped < b);
endmodule

// File: rtl/lcg_wide_carry.sv
module lcg_wide_carry #(
    parameter int LANE_W = 128
) (
    input  logic [LANE_W-1:0] a,
    input  logic [LANE_W-1:0] b,
    output logic              carry
);
    localparam int HALF_W = LANE_W / 2;

    logic lo_carry;

    assign lo_carry = (({1'b0, a[HALF_W-1:0]} + {1'b0, b[HALF_W-1:0]})
                       >= {1'b1, {HALF_W{1'b0}}});

    assign carry = (({1'b0, a[LANE_W-1:HALF_W]} + {1'b0, b[LANE_W-1:HALF_W]}
                     + {{HALF_W{1'b0}}, lo_carry})
                    >= {1'b1, {HALF_W{1'b0}}});
endmodule

// File: rtl/lcg_lane_bank.sv
module lcg_lane_bank #(
    parameter int LANE_W = 8,
    parameter int VEC_W  = 128
) (
    input  logic [VEC_W-1:0] a,
    input  logic [VEC_W-1:0] b,
    output logic [VEC_W-1:0] res
);
    import lcg_pkg::*;

    localparam int            NUM_LANES = VEC_W / LANE_W;
    localparam carry_method_e METHOD    = method_for(LANE_W);

    logic [NUM_LANES-1:0] lane_c;

    for (genvar k = 0; k < NUM_LANES; k++) begin : g_lane
        if (METHOD == CARRY_MASKED_MSB) begin : g_msb
            lcg_msb_carry #(.LANE_W(LANE_W)) u_c (
                .a     (a[k*LANE_W +: LANE_W]),
                .b     (b[k*LANE_W +: LANE_W]),
                .carry (lane_c[k])
            );
        end else if (METHOD == CARRY_COMPARE) begin : g_cmp
            lcg_cmp_carry #(.LANE_W(LANE_W)) u_c (
                .a     (a[k*LANE_W +: LANE_W]),
                .b     (b[k*LANE_W +: LANE_W]),
                .carry (lane_c[k])
            );
        end else begin : g_wide
            lcg_wide_carry #(.LANE_W(LANE_W)) u_c (
                .a     (a[k*LANE_W +: LANE_W]),
                .b     (b[k*LANE_W +: LANE_W]),
                .carry (lane_c[k])
            );
        end
        assign res[k*LANE_W +: LANE_W] = {{(LANE_W-1){1'b0}}, lane_c[k]};
    end
endmodule

// File: rtl/lane_carry_gen.sv
module lane_carry_gen (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       in_vld,
    input  logic [lcg_pkg::VEC_W-1:0]  op_a,
    input  logic [lcg_pkg::VEC_W-1:0]  op_b,
    input  logic [lcg_pkg::CODE_W-1:0] size_code,
    output logic                       out_vld,
    output logic [lcg_pkg::VEC_W-1:0]  res,
    output logic                       spec_err
);
    import lcg_pkg::*;

    logic [VEC_W-1:0] bank_res [NUM_SIZES];

    for (genvar s = 0; s < NUM_SIZES; s++) begin : g_size
        lcg_lane_bank #(
            .LANE_W (MIN_LANE_W << s),
            .VEC_W  (VEC_W)
        ) u_bank (
            .a   (op_a),
            .b   (op_b),
            .res (bank_res[s])
        );
    end

    out_state_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.vld = in_vld;
        if (in_vld) begin
            st_d.err = 1'b1;
            st_d.res = '0;
            for (int s = 0; s < NUM_SIZES; s++) begin
                if (size_code == s[CODE_W-1:0]) begin
                    st_d.err = 1'b0;
                    st_d.res = bank_res[s];
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign out_vld  = st_q.vld;
    assign res      = st_q.res;
    assign spec_err = st_q.err;
endmodule

// File: rtl/lcg_checker.sv
module lcg_checker (
    input logic                       clk,
    input logic                       rst,
    input logic                       in_vld,
    input logic [lcg_pkg::CODE_W-1:0] size_code,
    input logic                       out_vld,
    input logic [lcg_pkg::VEC_W-1:0]  res,
    input logic                       spec_err
);
    import lcg_pkg::*;

    function automatic logic [VEC_W-1:0] lane_lsb_mask(input logic [CODE_W-1:0] code);
        logic [VEC_W-1:0] m;
        int w;
        w = MIN_LANE_W << code;
        for (int i = 0; i < VEC_W; i++) m[i] = ((i % w) == 0);
        return m;
    endfunction

    a_r8_strobe: assert property (@(posedge clk) disable iff (rst)
        in_vld |=> out_vld);
    a_r8_no_spurious: assert property (@(posedge clk) disable iff (rst)
        !in_vld |=> !out_vld);
    a_r2_err_flag: assert property (@(posedge clk) disable iff (rst)
        in_vld |=> (spec_err == ($past(size_code) >= CODE_W'(NUM_SIZES))));
    a_r3_err_zero: assert property (@(posedge clk) disable iff (rst)
        spec_err |-> (res == '0));
    a_r4_lsb_only: assert property (@(posedge clk) disable iff (rst)
        (in_vld && size_code < CODE_W'(NUM_SIZES))
        |=> ((res & ~lane_lsb_mask($past(size_code))) == '0));
    a_r6_wide_upper: assert property (@(posedge clk) disable iff (rst)
        (in_vld && size_code == CODE_W'(NUM_SIZES - 1)) |=> (res[VEC_W-1:1] == '0));
    a_r9_hold: assert property (@(posedge clk) disable iff (rst)
        !in_vld |=> ($stable(res) && $stable(spec_err)));

    logic rst_seen_q;
    always_ff @(posedge clk) begin
        rst_seen_q <= rst;
        if (rst_seen_q === 1'b1) begin
            a_r10_reset_clear: assert (!out_vld && res == '0 && !spec_err);
        end
    end
endmodule

bind lane_carry_gen lcg_checker u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_vld    (in_vld),
    .size_code (size_code),
    .out_vld   (out_vld),
    .res       (res),
    .spec_err  (spec_err)
);

// File: tb/sim_lane_carry_gen.sv
module sim_lane_carry_gen;
    localparam int CLK_PERIOD = 10;
    localparam int VW = 128;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic           in_vld = 1'b0;
    logic [VW-1:0]  op_a = '0;
    logic [VW-1:0]  op_b = '0;
    logic [3:0]     size_code = '0;
    logic           out_vld;
    logic [VW-1:0]  res;
    logic           spec_err;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    lane_carry_gen u0 (
        .clk(clk), .rst(rst), .in_vld(in_vld), .op_a(op_a), .op_b(op_b),
        .size_code(size_code), .out_vld(out_vld), .res(res), .spec_err(spec_err)
    );

    // Bit-serial ripple add per lane; the final ripple bit is the extra sum bit.
    function automatic logic [VW-1:0] ref_carry(input logic [VW-1:0] a,
                                                input logic [VW-1:0] b,
                                                input int w);
        logic [VW-1:0] r;
        r = '0;
        for (int lane = 0; lane < VW / w; lane++) begin
            logic c;
            c = 1'b0;
            for (int k = 0; k < w; k++) begin
                int idx;
                idx = lane * w + k;
                c = (a[idx] & b[idx]) | ((a[idx] ^ b[idx]) & c);
            end
            r[lane * w] = c;
        end
        return r;
    endfunction

    function automatic logic [VW-1:0] rnd_vec();
        return {$urandom, $urandom, $urandom, $urandom};
    endfunction

    function automatic logic [VW-1:0] lane_fill(input int w, input logic [VW-1:0] pat,
                                                input int only_lane);
        logic [VW-1:0] v;
        v = '0;
        for (int i = 0; i < VW; i++)
            if (only_lane < 0 || (i / w) == only_lane) v[i] = pat[i % w];
        return v;
    endfunction

    task automatic check_vec(input bit ok, input string req,
                             input logic [VW-1:0] act, input logic [VW-1:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    // Issue one operation, check its result, then one idle cycle with junk inputs.
    task automatic run_op(input logic [VW-1:0] a, input logic [VW-1:0] b,
                          input logic [3:0] code, input string req);
        logic [VW-1:0] exp_r;
        logic          exp_e;
        exp_e = (code > 4'd4);
        exp_r = exp_e ? '0 : ref_carry(a, b, 8 << code);
        @(negedge clk);
        op_a = a; op_b = b; size_code = code; in_vld = 1'b1;
        @(negedge clk);
        in_vld = 1'b0;
        check_vec(out_vld === 1'b1, {req, " R8 out_vld"}, VW'(out_vld), VW'(1));
        check_vec(spec_err === exp_e, {req, " R2 spec_err"}, VW'(spec_err), VW'(exp_e));
        check_vec(res === exp_r, req, res, exp_r);
        op_a = rnd_vec(); op_b = rnd_vec(); size_code = 4'($urandom);
        @(negedge clk);
        check_vec(out_vld === 1'b0, "R9 idle out_vld", VW'(out_vld), VW'(0));
        check_vec(res === exp_r && spec_err === exp_e, "R9 hold res",
                  res, exp_r);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog act=%0d exp=%0d", 0, 1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R10: outputs clear while reset held
        check_vec(out_vld === 1'b0 && spec_err === 1'b0 && res === '0,
                  "R10 reset state", res, '0);
        rst = 1'b0;

        // R1 R4: exhaustive byte-lane pairs, 16 per vector
        for (int v = 0; v < 4096; v++) begin
            logic [VW-1:0] a, b;
            for (int j = 0; j < 16; j++) begin
                int p;
                p = v * 16 + j;
                a[j*8 +: 8] = 8'(p >> 8);
                b[j*8 +: 8] = 8'(p);
            end
            run_op(a, b, 4'd0, "R1 R4 byte sweep");
        end

        for (int code = 0; code < 5; code++) begin
            int w;
            logic [VW-1:0] ones, one, msb;
            w    = 8 << code;
            ones = '1;
            one  = VW'(1);
            msb  = VW'(1) << (w - 1);
            run_op(lane_fill(w, ones, -1), lane_fill(w, one, -1), 4'(code), "R4 ones plus one");
            run_op('0, '0, 4'(code), "R4 zero plus zero");
            run_op(lane_fill(w, msb, -1), lane_fill(w, msb, -1), 4'(code), "R4 msb only");
            run_op(lane_fill(w, msb, -1), '0, 4'(code), "R4 msb plus zero");
            // R5: lane 0 overflows, higher lanes all ones plus nothing
            run_op(ones, lane_fill(w, one, 0), 4'(code), "R5 no cross-lane carry");
            // R7: only the top lane overflows
            run_op(lane_fill(w, ones, (VW / w) - 1), lane_fill(w, one, (VW / w) - 1),
                   4'(code), "R7 lane order");
            for (int n = 0; n < 400; n++)
                run_op(rnd_vec(), rnd_vec(), 4'(code), "R1 R4 random");
        end

        // R6: carry rippling from the low half into the high half
        run_op({64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF}, VW'(1), 4'd4, "R6 full ripple");
        run_op({64'h7FFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF},
               {64'h8000_0000_0000_0000, 64'h0000_0000_0000_0001}, 4'd4, "R6 ripple into msb");
        run_op({64'h0, 64'hFFFF_FFFF_FFFF_FFFF}, {64'h0, 64'h1}, 4'd4, "R6 low carry only");

        // R2 R3: every illegal code
        for (int code = 5; code < 16; code++) begin
            run_op('1, '1, 4'(code), "R3 err zero result");
            run_op(rnd_vec(), rnd_vec(), 4'(code), "R2 err random");
        end

        // R10: reset during an accepted operation
        @(negedge clk);
        op_a = '1; op_b = '1; size_code = 4'd0; in_vld = 1'b1; rst = 1'b1;
        @(negedge clk);
        in_vld = 1'b0; rst = 1'b0;
        check_vec(out_vld === 1'b0 && spec_err === 1'b0 && res === '0,
                  "R10 reset mid-run", res, '0);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule